// File: doc/BRIEF.md
# Laplacian Cubic Sharpener

This block sharpens a pixel stream one sample at a time. For each accepted beat it takes a center pixel and the four pixels that touch it vertically and horizontally. It forms a signed second-difference edge value from them and raises that value to the third power, so that strong edges dominate weak ones. It then shrinks the cube by a power of two and clamps it. The shaped correction is added back to the center pixel, and the sum is saturated into the unsigned pixel range.

Neighbour extraction is done upstream. The block is only the arithmetic: five register stages, one result per clock when the stream flows. Both the input side and the output side use valid/ready handshakes. A beat transfers on a rising clock edge where valid and ready are both high.

Back-pressure stalls the whole pipeline as a unit. Input ready is high when the output register is empty or the consumer is taking its content. While the output is held, its valid and data must not change. Beats are never dropped or duplicated. Cycles with input valid low travel through the pipeline as empty slots and produce no output beat.

Top module: `lap_cube_sharpen`

## Requirements
- R1: The edge value is 4·ctr − nth − sth − est − wst, computed exactly as a signed 11-bit quantity (range −1020 to +1020).
- R2: The edge value is cubed at full precision (31-bit signed), and the cube carries the sign of the edge value.
- R3: The cube is scaled by dividing its magnitude by 2^SHIFT (SHIFT defaults to 12) and discarding the remainder. The original sign is then restored, so the rounding is toward zero and symmetric: an edge of +17 gives +1 and an edge of −17 gives −1.
- R4: The scaled correction is clamped to the range −255 to +255.
- R5: The output pixel is the center pixel plus the correction, clamped to 0..255.
- R6: When all five inputs are equal, the output equals the center pixel.
- R7: With out_ready held high, a beat accepted at clock edge k appears on out_valid/out_pix after edge k+4, which is a latency of 5 cycles. One result is produced per cycle.
- R8: While out_valid is high and out_ready is low, out_valid stays high, out_pix stays unchanged and in_ready is low. No beat is lost or repeated.
- R9: During and directly after reset, out_valid is low and in_ready is high.
- R10: A cycle with in_valid low creates no output beat. The output beats match the accepted input beats one for one and in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Pipeline can accept a beat this cycle |
| in_ctr | input | 8 | Center pixel |
| in_nth | input | 8 | Pixel above the center |
| in_sth | input | 8 | Pixel below the center |
| in_est | input | 8 | Pixel to the right of the center |
| in_wst | input | 8 | Pixel to the left of the center |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer accepts the output beat |
| out_pix | output | 8 | Sharpened pixel |

## Verification
Flat patches are swept over every center value. They confirm that a zero edge leaves the pixel untouched. A grid of uniform-neighbour cases is swept over center and neighbour levels, with positive and negative edges from zero up to full scale. These cases separate the sign handling of the cube from the two saturating stages. A coarse sweep with all four neighbours varied independently catches a misweighted or swapped neighbour term. Mirrored edge pairs of ±16 and ±17 tell truncation toward zero apart from floor rounding. Random ready and valid gaps drawn from an LFSR run throughout, exercising the stall hold, the bubbles and the order of the beats. A separate single-beat run measures the exact latency.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  localparam int DEF_PIX_W = 8;
  localparam int DEF_SHIFT = 12;

  // Width of the signed second difference: 4*max needs two extra bits, plus sign.
  function automatic int edge_width(input int pix_w);
    return pix_w + 3;
  endfunction

  // Width of the signed cube: three times the magnitude bits, plus sign.
  function automatic int cube_width(input int pix_w);
    return 3 * (pix_w + 2) + 1;
  endfunction

  // Width of the center-plus-correction sum before the final clamp.
  function automatic int sum_width(input int pix_w);
    return pix_w + 2;
  endfunction
endpackage

// File: rtl/lcs_delay.sv
module lcs_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] tap [DEPTH+1];

  assign tap[0] = d_i;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  tap[g+1] <= '0;
      else if (en) tap[g+1] <= tap[g];
    end
  end

  assign q_o = tap[DEPTH];
endmodule

// File: rtl/lcs_edge.sv
module lcs_edge #(
  parameter int PIX_W  = 8,
  parameter int EDGE_W = PIX_W + 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     vld_i,
  input  logic [PIX_W-1:0]         ctr_i,
  input  logic [PIX_W-1:0]         nth_i,
  input  logic [PIX_W-1:0]         sth_i,
  input  logic [PIX_W-1:0]         est_i,
  input  logic [PIX_W-1:0]         wst_i,
  output logic                     vld_o,
  output logic signed [EDGE_W-1:0] edge_o
);
  localparam int PAD = EDGE_W - PIX_W;

  logic signed [EDGE_W-1:0] c_x, n_x, s_x, e_x, w_x, lap;

  always_comb begin
    c_x = $signed({{PAD{1'b0}}, ctr_i});
    n_x = $signed({{PAD{1'b0}}, nth_i});
    s_x = $signed({{PAD{1'b0}}, sth_i});
    e_x = $signed({{PAD{1'b0}}, est_i});
    w_x = $signed({{PAD{1'b0}}, wst_i});
    lap = (c_x <<< 2) - n_x - s_x - e_x - w_x;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      edge_o <= '0;
    end else if (en) begin
      vld_o  <= vld_i;
      edge_o <= lap;
    end
  end
endmodule

// File: rtl/lcs_cube.sv
module lcs_cube #(
  parameter int EDGE_W = 11,
  parameter int CUBE_W = 31
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     vld_i,
  input  logic signed [EDGE_W-1:0] edge_i,
  output logic                     vld_o,
  output logic signed [CUBE_W-1:0] cube_o
);
  logic signed [CUBE_W-1:0] ext, prod;

  always_comb begin
    ext  = CUBE_W'(edge_i);
    prod = ext * ext * ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      cube_o <= '0;
    end else if (en) begin
      vld_o  <= vld_i;
      cube_o <= prod;
    end
  end

  // R2: a nonzero cube carries the sign of the edge it came from
  a_r2_cube_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (en && vld_i) |=> ((cube_o == '0) || (cube_o[CUBE_W-1] == $past(edge_i[EDGE_W-1]))));
endmodule

// File: rtl/lcs_divlim.sv
module lcs_divlim #(
  parameter int PIX_W  = 8,
  parameter int CUBE_W = 31,
  parameter int SHIFT  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    vld_i,
  input  logic signed [CUBE_W-1:0] cube_i,
  output logic                    vld_o,
  output logic signed [PIX_W:0]   corr_o
);
  localparam int MAXV = (1 << PIX_W) - 1;

  logic              neg;
  logic [CUBE_W-1:0] mag, scaled;
  logic [PIX_W-1:0]  lim;
  logic signed [PIX_W:0] corr;

  always_comb begin
    neg    = cube_i[CUBE_W-1];
    mag    = neg ? CUBE_W'(-cube_i) : CUBE_W'(cube_i);
    scaled = mag >> SHIFT;
    lim    = (scaled > CUBE_W'(MAXV)) ? PIX_W'(MAXV) : scaled[PIX_W-1:0];
    corr   = neg ? -$signed({1'b0, lim}) : $signed({1'b0, lim});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      corr_o <= '0;
    end else if (en) begin
      vld_o  <= vld_i;
      corr_o <= corr;
    end
  end

  // R3: scaling toward zero never flips the sign of the correction
  a_r3_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (en && vld_i) |=> ((corr_o == '0) || (corr_o[PIX_W] == $past(cube_i[CUBE_W-1]))));
endmodule

// File: rtl/lcs_addsat.sv
module lcs_addsat #(
  parameter int PIX_W = 8,
  parameter int SUM_W = PIX_W + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  vld_i,
  input  logic [PIX_W-1:0]      ctr_i,
  input  logic signed [PIX_W:0] corr_i,
  output logic                  vld_o,
  output logic [PIX_W-1:0]      pix_o
);
  localparam int MAXV = (1 << PIX_W) - 1;
  localparam logic signed [SUM_W-1:0] SMAX = SUM_W'(MAXV);

  logic                    vld_sum;
  logic signed [SUM_W-1:0] sum_r, sum_c;
  logic [PIX_W-1:0]        pix_c;

  always_comb begin
    sum_c = $signed({2'b00, ctr_i}) + SUM_W'(corr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_sum <= 1'b0;
      sum_r   <= '0;
    end else if (en) begin
      vld_sum <= vld_i;
      sum_r   <= sum_c;
    end
  end

  always_comb begin
    if (sum_r[SUM_W-1])   pix_c = '0;
    else if (sum_r > SMAX) pix_c = PIX_W'(MAXV);
    else                   pix_c = sum_r[PIX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      pix_o <= '0;
    end else if (en) begin
      vld_o <= vld_sum;
      pix_o <= pix_c;
    end
  end

  // R5: a non-negative correction never lowers the center value in the sum
  a_r5_add_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    (en && vld_i && !corr_i[PIX_W]) |=> (sum_r >= $signed({2'b00, $past(ctr_i)})));
endmodule

// File: rtl/lap_cube_sharpen.sv
module lap_cube_sharpen
  import lcs_pkg::*;
#(
  parameter int PIX_W = DEF_PIX_W,
  parameter int SHIFT = DEF_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_ctr,
  input  logic [PIX_W-1:0] in_nth,
  input  logic [PIX_W-1:0] in_sth,
  input  logic [PIX_W-1:0] in_est,
  input  logic [PIX_W-1:0] in_wst,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_pix
);
  localparam int EDGE_W = edge_width(PIX_W);
  localparam int CUBE_W = cube_width(PIX_W);
  localparam int SUM_W  = sum_width(PIX_W);
  localparam int C_LAG  = 3;

  logic                    adv;
  logic                    v1, v2, v3;
  logic signed [EDGE_W-1:0] edge_s1;
  logic signed [CUBE_W-1:0] cube_s2;
  logic signed [PIX_W:0]    corr_s3;
  logic [PIX_W-1:0]         ctr_s3;

  // The whole pipeline advances together; the output register is the only holder.
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  lcs_edge #(.PIX_W(PIX_W), .EDGE_W(EDGE_W)) u_edge (
    .clk(clk), .rst_n(rst_n), .en(adv), .vld_i(in_valid),
    .ctr_i(in_ctr), .nth_i(in_nth), .sth_i(in_sth), .est_i(in_est), .wst_i(in_wst),
    .vld_o(v1), .edge_o(edge_s1)
  );

  lcs_cube #(.EDGE_W(EDGE_W), .CUBE_W(CUBE_W)) u_cube (
    .clk(clk), .rst_n(rst_n), .en(adv), .vld_i(v1),
    .edge_i(edge_s1), .vld_o(v2), .cube_o(cube_s2)
  );

  lcs_divlim #(.PIX_W(PIX_W), .CUBE_W(CUBE_W), .SHIFT(SHIFT)) u_divlim (
    .clk(clk), .rst_n(rst_n), .en(adv), .vld_i(v2),
    .cube_i(cube_s2), .vld_o(v3), .corr_o(corr_s3)
  );

  lcs_delay #(.W(PIX_W), .DEPTH(C_LAG)) u_ctr_lag (
    .clk(clk), .rst_n(rst_n), .en(adv), .d_i(in_ctr), .q_o(ctr_s3)
  );

  lcs_addsat #(.PIX_W(PIX_W), .SUM_W(SUM_W)) u_addsat (
    .clk(clk), .rst_n(rst_n), .en(adv), .vld_i(v3),
    .ctr_i(ctr_s3), .corr_i(corr_s3), .vld_o(out_valid), .pix_o(out_pix)
  );

  // R8: a refused output beat is held unchanged
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

  // R8: no beat enters while the output is held
  a_r8_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/lap_cube_sharpen_tb_top.sv
module lap_cube_sharpen_tb_top;
  localparam int SHIFT = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, out_ready = 1'b0;
  logic       in_ready, out_valid;
  logic [7:0] in_ctr = '0, in_nth = '0, in_sth = '0, in_est = '0, in_wst = '0;
  logic [7:0] out_pix;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  logic [39:0] stim_q[$];
  string       stag_q[$];
  int          exp_q[$];
  string       etag_q[$];

  always #5 clk = ~clk;

  lap_cube_sharpen #(.PIX_W(8), .SHIFT(SHIFT)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ctr(in_ctr), .in_nth(in_nth), .in_sth(in_sth), .in_est(in_est), .in_wst(in_wst),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
  );

  function automatic int model(input int c, input int n, input int s, input int e, input int w);
    longint lap, cu, mag;
    int corr, sum;
    lap = 4 * c - n - s - e - w;
    cu  = lap * lap * lap;
    mag = (cu < 0) ? -cu : cu;
    mag = mag >> SHIFT;
    if (mag > 255) mag = 255;
    corr = (cu < 0) ? -int'(mag) : int'(mag);
    sum = c + corr;
    if (sum < 0) sum = 0;
    if (sum > 255) sum = 255;
    return sum;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic add(input string tag, input int c, input int n, input int s, input int e, input int w);
    stim_q.push_back({c[7:0], n[7:0], s[7:0], e[7:0], w[7:0]});
    stag_q.push_back(tag);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 190000);
        finish_run();
      end
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    int idx = 0;
    int lat;
    logic held = 1'b0;
    logic [7:0] held_pix = '0;

    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9 out_valid in reset", int'(out_valid), 0);
    check("R9 in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 out_valid after reset", int'(out_valid), 0);
    check("R9 in_ready after reset", int'(in_ready), 1);

    // R7: single beat latency with ready held high
    out_ready = 1'b1;
    in_valid = 1'b1;
    in_ctr = 8'd100; in_nth = 8'd96; in_sth = 8'd96; in_est = 8'd96; in_wst = 8'd95;
    #1;
    check("R7 empty before", int'(out_valid), 0);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check("R7 latency", lat, 5);
    check("R7 latency value", int'(out_pix), model(100, 96, 96, 96, 95));
    @(negedge clk);
    check("R10 no beat from idle", int'(out_valid), 0);

    // stimulus build
    for (int c = 0; c < 256; c++) add("R6", c, c, c, c, c);
    add("R3", 100, 105, 104, 104, 104);
    add("R3", 100, 96, 96, 96, 95);
    add("R3", 100, 104, 104, 104, 104);
    add("R3", 100, 96, 96, 96, 96);
    add("R4", 255, 0, 0, 0, 0);
    add("R4", 0, 255, 255, 255, 255);
    add("R4", 128, 0, 0, 0, 0);
    add("R4", 10, 40, 40, 40, 40);
    for (int c = 0; c < 256; c += 5)
      for (int v = 0; v < 256; v += 5) add("R2", c, v, v, v, v);
    for (int c = 0; c < 256; c += 17)
      for (int n = 0; n < 256; n += 51)
        for (int s = 0; s < 256; s += 51)
          for (int e = 0; e < 256; e += 51)
            for (int w = 0; w < 256; w += 51) add("R1", c, n, s, e, w);

    // streaming with random gaps and stalls
    while (idx < stim_q.size() || exp_q.size() > 0) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (held) begin
        check("R8 held valid", int'(out_valid), 1);
        check("R8 held data", int'(out_pix), int'(held_pix));
      end
      in_valid = (idx < stim_q.size()) && (lfsr[2:0] != 3'd0);
      if (idx < stim_q.size()) {in_ctr, in_nth, in_sth, in_est, in_wst} = stim_q[idx];
      out_ready = (lfsr[5:4] != 2'd0);
      #1;
      held = out_valid && !out_ready;
      held_pix = out_pix;
      if (held) check("R8 in_ready low", int'(in_ready), 0);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check("R10 spurious beat", 1, 0);
        end else begin
          check({etag_q[0], " R5 R10"}, int'(out_pix), exp_q[0]);
          void'(exp_q.pop_front());
          void'(etag_q.pop_front());
        end
      end
      if (in_valid && in_ready) begin
        exp_q.push_back(model(int'(in_ctr), int'(in_nth), int'(in_sth), int'(in_est), int'(in_wst)));
        etag_q.push_back(stag_q[idx]);
        idx++;
      end
    end

    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (8) begin
      @(negedge clk);
      #1;
      if (out_valid) check("R10 extra beat after drain", 1, 0);
    end
    check("R10 all beats drained", exp_q.size(), 0);
    finish_run();
  end
endmodule